// File: doc/BRIEF.md
# Quarter-Step Fractional-N Divider Pair

This block holds the two frequency dividers that feed a phase detector in a fractional-N synthesizer. A reference divider turns enable ticks from the reference clock into one output pulse every R ticks. A main divider turns enable ticks from the oscillator clock into one output pulse at the end of each period of N or N+1 ticks. A two-bit accumulator chooses between N and N+1 for each period, so that the average main period is N + k/4 ticks.

The block runs on one system clock. Each of the two source clocks reaches it as a one-cycle enable strobe. The control side writes a 15-bit effective main ratio and a 9-bit reference word, then raises an update request together with a valid flag. Both dividers stay idle and silent until the first valid update arrives. After that, each new setting waits inside the block until the divider it belongs to reaches the end of a period while the charge pump is idle. A test bit routes both divided pulses to two monitor outputs.

Top module: `fracn_divider_pair`

## Requirements
- R1: From reset until the first update request that has upd_valid high, ref_pulse, main_pulse, mon_a and mon_c all stay 0. A request with upd_valid low is ignored at every point.
- R2: The integer part N is main_word[14:2] and the quarter fraction k is main_word[1:0]. Every main period, counted in osc_en ticks, lasts either N or N+1 ticks.
- R3: In any four consecutive main periods with the same k, exactly k periods last N+1 ticks. The choice comes from the carry of a 2-bit accumulator that adds k once per period. The accumulator is cleared at the first configuration, so the first period lasts N ticks.
- R4: Every reference period lasts exactly R ticks of ref_en, where R is the 9-bit reference word.
- R5: A main word below 2048 is raised to 2048. A reference word below 36 is raised to 36.
- R6: The first accepted update configures both dividers together on the cycle after the request is captured. This happens whatever the value of cp_busy. The first main pulse then follows after N osc_en ticks, and the first reference pulse after R ref_en ticks.
- R7: Once the dividers are configured, a new setting takes effect only on a terminal tick of its own divider while cp_busy is low. Otherwise the setting is held. The period in progress finishes with the old ratio.
- R8: A request that arrives while an earlier one is still pending replaces it. Only the newest words are applied.
- R9: mon_a equals ref_pulse and mon_c equals main_pulse while test_en is 1. Both monitors are 0 while test_en is 0.
- R10: Each divided pulse is one clock wide. It is registered and appears on the cycle after the enable tick that ends the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | One-cycle strobe for each reference clock edge |
| osc_en | input | 1 | One-cycle strobe for each oscillator clock edge |
| main_word | input | 15 | Effective main ratio, 4N + k |
| ref_word | input | 9 | Reference division ratio R |
| upd_req | input | 1 | Update request, sampled each cycle |
| upd_valid | input | 1 | Marks the words as a complete setting |
| cp_busy | input | 1 | Charge pump is sourcing or sinking |
| test_en | input | 1 | Routes the divided pulses to the monitors |
| ref_pulse | output | 1 | Divided reference pulse |
| main_pulse | output | 1 | Divided oscillator pulse |
| mon_a | output | 1 | Monitor copy of ref_pulse |
| mon_c | output | 1 | Monitor copy of main_pulse |

## Verification
The hardest case to reach is a setting that has to wait. This happens when a terminal tick lands while the charge pump is busy, the setting is replaced before it can be applied, and the fractional accumulator must carry its phase across the change of ratio. The stimulus holds cp_busy high across many terminal ticks and stacks two requests. It then releases cp_busy and measures the period lengths, and it checks that every group of four periods still sums to 4N + k. A long random phase follows, with sparse enables, a toggling busy flag and occasional requests. In that phase a behavioural model that tracks the accumulated fraction as an unbounded sum is compared against the outputs on every clock.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

  localparam int DEF_MAIN_W  = 15;
  localparam int DEF_REF_W   = 9;
  localparam int DEF_FRAC_W  = 2;
  localparam int DEF_MAIN_MIN = 2048;
  localparam int DEF_REF_MIN  = 36;

  // raise a ratio word to the smallest legal value
  function automatic int unsigned lift_to_min(input int unsigned v, input int unsigned lo);
    return (v < lo) ? lo : v;
  endfunction

endpackage

// File: rtl/fracn_upd_hold.sv
module fracn_upd_hold #(
  parameter int W    = 15,
  parameter int MINV = 2048
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  input  logic [W-1:0] word_in,
  input  logic         apply,
  output logic         pend,
  output logic [W-1:0] word_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      word_q <= '0;
    end else if (req) begin
      pend   <= 1'b1;
      word_q <= word_in;
    end else if (apply) begin
      pend   <= 1'b0;
    end
  end

  AST_PEND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (word_q >= W'(MINV))); // R5

  AST_PEND_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !apply && !req) |=> (pend && $stable(word_q))); // R7

  AST_NEWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> (pend && word_q == $past(word_in))); // R8

endmodule

// File: rtl/fracn_div_stage.sv
module fracn_div_stage #(
  parameter int CW      = 13,
  parameter int FW      = 2,
  parameter bit FRAC_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          cp_busy,
  input  logic          pend,
  input  logic [CW-1:0] ratio_new,
  input  logic [FW-1:0] frac_new,
  output logic          apply,
  output logic          tc,
  output logic          cfgd,
  output logic          pulse
);

  logic [CW-1:0] ratio_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] ratio_use;
  logic          carry;

  // count to load at a period boundary: ratio-1, plus one for a long period
  function automatic logic [CW-1:0] reload(input logic [CW-1:0] r, input logic c);
    return r - CW'(1) + CW'(c);
  endfunction

  assign tc        = cfgd && tick_en && (cnt_q == '0);
  assign apply     = pend && (!cfgd || (tc && !cp_busy));
  assign ratio_use = apply ? ratio_new : ratio_q;

  generate
    if (FRAC_EN) begin : g_frac
      logic [FW-1:0] frac_q;
      logic [FW-1:0] acc_q;
      logic [FW-1:0] frac_use;
      logic [FW-1:0] acc_sum;

      assign frac_use         = apply ? frac_new : frac_q;
      assign {carry, acc_sum} = {1'b0, acc_q} + {1'b0, frac_use};

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          frac_q <= '0;
          acc_q  <= '0;
        end else if (apply && !cfgd) begin
          frac_q <= frac_new;
          acc_q  <= '0;
        end else if (tc) begin
          frac_q <= frac_use;
          acc_q  <= acc_sum;
        end
      end

      AST_WHOLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && !apply && frac_q == '0) |=> (cnt_q == ratio_q - CW'(1))); // R3
    end else begin : g_int
      logic unused_frac;
      assign unused_frac = ^frac_new;
      assign carry       = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgd    <= 1'b0;
      ratio_q <= '0;
      cnt_q   <= '0;
      pulse   <= 1'b0;
    end else begin
      pulse <= tc;
      if (apply && !cfgd) begin
        cfgd    <= 1'b1;
        ratio_q <= ratio_new;
        cnt_q   <= reload(ratio_new, 1'b0);
      end else if (tc) begin
        ratio_q <= ratio_use;
        cnt_q   <= reload(ratio_use, carry);
      end else if (cfgd && tick_en) begin
        cnt_q   <= cnt_q - CW'(1);
      end
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cfgd |-> (cnt_q <= ratio_q)); // R2

  AST_PULSE_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse); // R10

  AST_SILENT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgd |=> !pulse); // R1

endmodule

// File: rtl/fracn_divider_pair.sv
module fracn_divider_pair
  import fracn_pkg::*;
#(
  parameter int MAIN_W   = DEF_MAIN_W,
  parameter int REF_W    = DEF_REF_W,
  parameter int FRAC_W   = DEF_FRAC_W,
  parameter int MAIN_MIN = DEF_MAIN_MIN,
  parameter int REF_MIN  = DEF_REF_MIN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_en,
  input  logic              osc_en,
  input  logic [MAIN_W-1:0] main_word,
  input  logic [REF_W-1:0]  ref_word,
  input  logic              upd_req,
  input  logic              upd_valid,
  input  logic              cp_busy,
  input  logic              test_en,
  output logic              ref_pulse,
  output logic              main_pulse,
  output logic              mon_a,
  output logic              mon_c
);

  localparam int N_W = MAIN_W - FRAC_W;

  logic              take_req;
  logic [MAIN_W-1:0] main_lifted;
  logic [REF_W-1:0]  ref_lifted;
  logic              m_pend, r_pend;
  logic [MAIN_W-1:0] m_word;
  logic [REF_W-1:0]  r_word;
  logic              m_apply, m_tc, m_cfgd;
  logic              r_apply, r_tc, r_cfgd;

  assign take_req    = upd_req && upd_valid;
  assign main_lifted = MAIN_W'(lift_to_min(32'(main_word), 32'(MAIN_MIN)));
  assign ref_lifted  = REF_W'(lift_to_min(32'(ref_word), 32'(REF_MIN)));

  fracn_upd_hold #(.W(MAIN_W), .MINV(MAIN_MIN)) u_main_hold (
    .clk(clk), .rst_n(rst_n), .req(take_req), .word_in(main_lifted),
    .apply(m_apply), .pend(m_pend), .word_q(m_word)
  );

  fracn_upd_hold #(.W(REF_W), .MINV(REF_MIN)) u_ref_hold (
    .clk(clk), .rst_n(rst_n), .req(take_req), .word_in(ref_lifted),
    .apply(r_apply), .pend(r_pend), .word_q(r_word)
  );

  fracn_div_stage #(.CW(N_W), .FW(FRAC_W), .FRAC_EN(1'b1)) u_main_div (
    .clk(clk), .rst_n(rst_n), .tick_en(osc_en), .cp_busy(cp_busy),
    .pend(m_pend), .ratio_new(m_word[MAIN_W-1:FRAC_W]),
    .frac_new(m_word[FRAC_W-1:0]),
    .apply(m_apply), .tc(m_tc), .cfgd(m_cfgd), .pulse(main_pulse)
  );

  fracn_div_stage #(.CW(REF_W), .FW(FRAC_W), .FRAC_EN(1'b0)) u_ref_div (
    .clk(clk), .rst_n(rst_n), .tick_en(ref_en), .cp_busy(cp_busy),
    .pend(r_pend), .ratio_new(r_word), .frac_new('0),
    .apply(r_apply), .tc(r_tc), .cfgd(r_cfgd), .pulse(ref_pulse)
  );

  assign mon_a = test_en & ref_pulse;
  assign mon_c = test_en & main_pulse;

  AST_NO_APPLY_BUSY_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (m_apply && m_cfgd) |-> (!cp_busy && m_tc)); // R7

  AST_NO_APPLY_BUSY_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (r_apply && r_cfgd) |-> (!cp_busy && r_tc)); // R7

  AST_JOINT_CONFIG: assert property (@(posedge clk) disable iff (!rst_n)
    m_cfgd == r_cfgd); // R6

  AST_FIRST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_cfgd) |-> $past(m_pend)); // R6

endmodule

// File: tb/fracn_divider_pair_tb.sv
module fracn_divider_pair_tb_top;

  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_en = 1'b1, osc_en = 1'b1;
  logic [14:0] main_word = '0;
  logic [8:0]  ref_word = '0;
  logic        upd_req = 1'b0, upd_valid = 1'b0, cp_busy = 1'b0, test_en = 1'b0;
  logic        ref_pulse, main_pulse, mon_a, mon_c;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 1'b0;

  fracn_divider_pair dut_i (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .osc_en(osc_en),
    .main_word(main_word), .ref_word(ref_word), .upd_req(upd_req),
    .upd_valid(upd_valid), .cp_busy(cp_busy), .test_en(test_en),
    .ref_pulse(ref_pulse), .main_pulse(main_pulse), .mon_a(mon_a), .mon_c(mon_c)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int lift_b(input int v, input int lo);
    if (v < lo) return lo;
    return v;
  endfunction

  // behavioural model: fraction tracked as an unbounded running sum
  bit m_cfg, m_pend, r_cfg, r_pend, e_main, e_ref;
  int m_n, m_k, m_tot, m_left, r_n, r_left, pm, pr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = 0; m_pend = 0; r_cfg = 0; r_pend = 0; e_main = 0; e_ref = 0;
      m_n = 0; m_k = 0; m_tot = 0; m_left = 0; r_n = 0; r_left = 0; pm = 0; pr = 0;
    end else begin
      bit tcm, tcr, used_m, used_r;
      int extra;
      tcm = m_cfg && osc_en && (m_left == 0);
      tcr = r_cfg && ref_en && (r_left == 0);
      used_m = 0; used_r = 0;
      if (m_pend && !m_cfg) begin
        m_n = pm / 4; m_k = pm % 4; m_tot = 0; m_left = m_n - 1; m_cfg = 1; used_m = 1;
      end else if (tcm) begin
        if (m_pend && !cp_busy) begin m_n = pm / 4; m_k = pm % 4; used_m = 1; end
        extra = ((m_tot + m_k) / 4) - (m_tot / 4);
        m_tot += m_k;
        m_left = m_n - 1 + extra;
      end else if (m_cfg && osc_en) m_left--;
      if (r_pend && !r_cfg) begin
        r_n = pr; r_left = r_n - 1; r_cfg = 1; used_r = 1;
      end else if (tcr) begin
        if (r_pend && !cp_busy) begin r_n = pr; used_r = 1; end
        r_left = r_n - 1;
      end else if (r_cfg && ref_en) r_left--;
      if (used_m) m_pend = 0;
      if (used_r) r_pend = 0;
      e_main = tcm; e_ref = tcr;
      if (upd_req && upd_valid) begin
        m_pend = 1; r_pend = 1;
        pm = lift_b(int'(main_word), 2048);
        pr = lift_b(int'(ref_word), 36);
      end
    end
  end

  // interval recording and per-cycle comparison, away from the edge
  int main_iv[$], ref_iv[$];
  int last_m = -1, last_r = -1, n_main = 0, n_ref = 0, n_mona = 0, n_monc = 0;

  always @(posedge clk) begin
    #2;
    cyc++;
    if (rst_n && !done) begin
      check(main_pulse == e_main, "R2 R3 R6 R7 R10 main_pulse", main_pulse, e_main);
      check(ref_pulse == e_ref, "R4 R6 R7 R10 ref_pulse", ref_pulse, e_ref);
      check(mon_a == (e_ref && test_en), "R9 mon_a", mon_a, e_ref && test_en);
      check(mon_c == (e_main && test_en), "R9 mon_c", mon_c, e_main && test_en);
      if (main_pulse) begin
        n_main++;
        if (last_m >= 0) main_iv.push_back(cyc - last_m);
        last_m = cyc;
      end
      if (ref_pulse) begin
        n_ref++;
        if (last_r >= 0) ref_iv.push_back(cyc - last_r);
        last_r = cyc;
      end
      if (mon_a) n_mona++;
      if (mon_c) n_monc++;
    end
  end

  task automatic clear_meas();
    main_iv.delete(); ref_iv.delete();
    last_m = -1; last_r = -1;
    n_main = 0; n_ref = 0; n_mona = 0; n_monc = 0;
  endtask

  task automatic send(input int mw, input int rw, input bit vld);
    @(negedge clk);
    main_word = 15'(mw); ref_word = 9'(rw); upd_valid = vld; upd_req = 1'b1;
    @(negedge clk);
    upd_req = 1'b0; upd_valid = 1'b0;
  endtask

  task automatic check_range(ref int q[$], input int lo, input int hi, input string tag);
    int bad = -1;
    foreach (q[i]) if (bad < 0 && (q[i] < lo || q[i] > hi)) bad = q[i];
    check(q.size() > 2, {tag, " interval count"}, q.size(), 3);
    check(bad < 0, {tag, " interval"}, bad, lo);
  endtask

  task automatic check_sum4(ref int q[$], input int s, input string tag);
    int bad = -1;
    for (int i = 0; i + 3 < q.size(); i++) begin
      int t;
      t = q[i] + q[i+1] + q[i+2] + q[i+3];
      if (bad < 0 && t != s) bad = t;
    end
    check(bad < 0, {tag, " four-period sum"}, bad, s);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(!ref_pulse && !main_pulse && !mon_a && !mon_c, "R1 reset outputs",
          int'({ref_pulse, main_pulse, mon_a, mon_c}), 0);
    rst_n = 1'b1;

    // R1: invalid request leaves the block idle
    clear_meas();
    send(2403, 40, 1'b0);
    repeat (1500) @(negedge clk);
    check(n_main == 0, "R1 main idle after invalid request", n_main, 0);
    check(n_ref == 0, "R1 ref idle after invalid request", n_ref, 0);

    // R2 R3 R4 R9: N=600 k=3, R=40, monitors on
    test_en = 1'b1;
    clear_meas();
    send(4 * 600 + 3, 40, 1'b1);
    repeat (6000) @(negedge clk);
    check_range(main_iv, 600, 601, "R2");
    check_sum4(main_iv, 2403, "R3");
    check_range(ref_iv, 40, 40, "R4");
    check(n_mona == n_ref, "R9 mon_a follows ref", n_mona, n_ref);
    check(n_monc == n_main, "R9 mon_c follows main", n_monc, n_main);

    // R5: words below minimum are raised; monitors off
    test_en = 1'b0;
    send(100, 5, 1'b1);
    repeat (1500) @(negedge clk);
    clear_meas();
    repeat (3000) @(negedge clk);
    check_range(main_iv, 512, 512, "R5 main");
    check_range(ref_iv, 36, 36, "R5 ref");
    check(n_mona == 0 && n_monc == 0, "R9 monitors off", n_mona + n_monc, 0);

    // R7 R8: busy defers, newer request replaces older
    cp_busy = 1'b1;
    send(4 * 700 + 1, 50, 1'b1);
    clear_meas();
    repeat (3000) @(negedge clk);
    check_range(main_iv, 512, 512, "R7 main held while busy");
    check_range(ref_iv, 36, 36, "R7 ref held while busy");
    send(4 * 800 + 2, 60, 1'b1);
    repeat (1000) @(negedge clk);
    cp_busy = 1'b0;
    repeat (1500) @(negedge clk);
    clear_meas();
    repeat (4000) @(negedge clk);
    check_range(main_iv, 800, 801, "R8 main newest word");
    check_sum4(main_iv, 3202, "R8 R3");
    check_range(ref_iv, 60, 60, "R8 ref newest word");

    // random phase, compared against the model every cycle (R6 R7 R10)
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      osc_en    = ($urandom % 4) != 0;
      ref_en    = ($urandom % 3) != 0;
      main_word = 15'(1500 + $urandom % 8000);
      ref_word  = 9'(20 + $urandom % 180);
      upd_req   = ($urandom % 1500) == 0;
      upd_valid = ($urandom % 4) != 0;
      if (i % 97 == 0) cp_busy = $urandom % 2;
      if (i % 1000 == 0) test_en = ~test_en;
    end
    @(negedge clk);
    upd_req = 1'b0;
    repeat (10) @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL R1 watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule